// File: doc/BRIEF.md
# Decode-Stage Branch Resolver with Delay Slot

This block produces the next fetch address for a scalar pipeline that settles conditional branches in the decode stage. The decode stage offers one decoded instruction per cycle on a valid/ready handshake. The offer carries the instruction's address, a branch flag, the compare kind (equal or not-equal), a signed word offset, the two source register indices and the two operand values. The block has its own adder, which forms the branch destination, and its own equality comparator, which settles the condition. From these it picks either the sequential address or the destination as the next fetch address.

The pipeline uses delayed branching. While a branch sits in decode, the fetch stage is already reading the following word, and that word always executes. A taken branch therefore changes the fetch address only after that one slot, and the slot is never discarded. A branch that lands in a delay slot is illegal, and the block resolves it as not taken. A compare that depends on a load still in the execute stage holds decode until the loaded value can be forwarded.

Back-pressure follows these rules. `dec_ready` drops only for a load-use hazard on a branch. While it is low, nothing in the block changes state. An offer is taken in a cycle where both `dec_valid` and `dec_ready` are high. When `dec_valid` is low, fetch still advances sequentially and the slot state is held.

Top module: `bres_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `fetch_addr` is 0 and `in_slot` is 0.
- R2: In a cycle where `dec_ready` is 1 and `take_branch` is 0, the next `fetch_addr` is the current `fetch_addr` plus 4.
- R3: `branch_dest` always equals `dec_pc` plus the 16-bit signed `dec_offset` sign-extended and shifted left by 2, modulo 2^32.
- R4: `take_branch` is 1 only for an accepted branch (`dec_valid`=1, `dec_is_branch`=1, `dec_ready`=1, `in_slot`=0). For such a branch, `take_branch` is 1 exactly when the operands are equal with `dec_cmp_ne`=0, or differ with `dec_cmp_ne`=1.
- R5: In a cycle where `take_branch` is 1, the next `fetch_addr` equals that cycle's `branch_dest`.
- R6: Accepting a branch that is not itself in a slot sets `in_slot` to 1. Accepting any instruction while `in_slot` is 1 clears it. The delay-slot instruction is accepted normally and is never dropped.
- R7: A branch accepted while `in_slot` is 1 is not taken, and `fetch_addr` advances by 4.
- R8: When a branch is offered while `ld_in_ex` is 1 and `ld_dest` is nonzero and equal to `dec_src_a` or `dec_src_b`, `dec_ready` is 0. In that case `fetch_addr` and `in_slot` hold and `take_branch` is 0.
- R9: A load whose destination is register 0, or an offer that is not a branch, never stalls.
- R10: With `dec_valid`=0, `fetch_addr` advances by 4 and `in_slot` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode holds an instruction |
| dec_ready | output | 1 | Decode may advance (low on load-use stall) |
| dec_pc | input | 32 | Address of the instruction in decode |
| dec_is_branch | input | 1 | Instruction is a conditional branch |
| dec_cmp_ne | input | 1 | 0 = branch if equal, 1 = branch if not equal |
| dec_offset | input | 16 | Signed word offset of the branch |
| dec_src_a | input | 5 | First compare register index |
| dec_src_b | input | 5 | Second compare register index |
| dec_opnd_a | input | 32 | First compare operand value |
| dec_opnd_b | input | 32 | Second compare operand value |
| ld_in_ex | input | 1 | A load occupies the execute stage |
| ld_dest | input | 5 | Destination register of that load |
| fetch_addr | output | 32 | Address to fetch next |
| take_branch | output | 1 | Accepted branch resolved taken this cycle |
| branch_dest | output | 32 | Computed branch destination |
| in_slot | output | 1 | Instruction in decode is a delay slot |

## Verification
Four rules are checked by assertions on every clock edge. Fetch moves by 4 after a cycle that neither stalls nor takes a branch. A taken branch lands on the destination computed in the previous cycle. A stall freezes the fetch address and never takes a branch. A slot never takes a branch, and accepting a branch always opens one. Only the bench's scenarios can show that the compare result is correct for equal and unequal operands of both kinds, that negative offsets wrap properly, that register 0 and non-branch offers never stall, and that bubbles keep the slot state. It does this with a reference model that tracks fetch address, slot state and decode address, checked every cycle over directed and pseudo-random streams.

// File: rtl/bres_pkg.sv
package bres_pkg;
  typedef enum logic {
    CMP_EQ = 1'b0,
    CMP_NE = 1'b1
  } cmp_kind_e;

  typedef struct packed {
    logic stall;
    logic cond;
    logic accept;
  } resolve_s;
endpackage

// File: rtl/bres_dest_adder.sv
module bres_dest_adder #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] dest
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] disp;

  always_comb begin
    disp = {{EXT_W{offset[OFF_W-1]}}, offset} << SHIFT;
    dest = base + disp;
  end
endmodule

// File: rtl/bres_compare.sv
module bres_compare
  import bres_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  cmp_kind_e         kind,
  output logic              cond
);
  logic [DATA_W-1:0] diff;
  logic              same;

  always_comb begin
    diff = opnd_a ^ opnd_b;
    same = ~|diff;
    cond = (kind == CMP_NE) ? ~same : same;
  end
endmodule

// File: rtl/bres_hazard.sv
module bres_hazard #(
  parameter int REG_W = 5,
  parameter int N_SRC = 2
) (
  input  logic                        need,
  input  logic                        ld_valid,
  input  logic [REG_W-1:0]            ld_reg,
  input  logic [N_SRC-1:0][REG_W-1:0] srcs,
  output logic                        stall
);
  logic [N_SRC-1:0] hit;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign hit[i] = (srcs[i] == ld_reg);
  end

  assign stall = need & ld_valid & (|ld_reg) & (|hit);
endmodule

// File: rtl/bres_top.sv
module bres_top
  import bres_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int OFF_W      = 16,
  parameter int REG_W      = 5,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  output logic              dec_ready,
  input  logic [ADDR_W-1:0] dec_pc,
  input  logic              dec_is_branch,
  input  logic              dec_cmp_ne,
  input  logic [OFF_W-1:0]  dec_offset,
  input  logic [REG_W-1:0]  dec_src_a,
  input  logic [REG_W-1:0]  dec_src_b,
  input  logic [DATA_W-1:0] dec_opnd_a,
  input  logic [DATA_W-1:0] dec_opnd_b,
  input  logic              ld_in_ex,
  input  logic [REG_W-1:0]  ld_dest,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              take_branch,
  output logic [ADDR_W-1:0] branch_dest,
  output logic              in_slot
);
  localparam int                SHIFT = $clog2(INSN_BYTES);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(INSN_BYTES);

  resolve_s          rs;
  logic [ADDR_W-1:0] seq_addr;
  logic              is_br_offer;

  assign is_br_offer = dec_valid & dec_is_branch;

  bres_dest_adder #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_add (
    .base  (dec_pc),
    .offset(dec_offset),
    .dest  (branch_dest)
  );

  bres_compare #(.DATA_W(DATA_W)) u_cmp (
    .opnd_a(dec_opnd_a),
    .opnd_b(dec_opnd_b),
    .kind  (cmp_kind_e'(dec_cmp_ne)),
    .cond  (rs.cond)
  );

  bres_hazard #(.REG_W(REG_W), .N_SRC(2)) u_haz (
    .need    (is_br_offer),
    .ld_valid(ld_in_ex),
    .ld_reg  (ld_dest),
    .srcs    ({dec_src_b, dec_src_a}),
    .stall   (rs.stall)
  );

  assign rs.accept = dec_valid & ~rs.stall;
  assign dec_ready = ~rs.stall;
  assign take_branch = rs.accept & dec_is_branch & ~in_slot & rs.cond;
  assign seq_addr = fetch_addr + STEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_addr <= '0;
      in_slot    <= 1'b0;
    end else begin
      if (!rs.stall) begin
        fetch_addr <= take_branch ? branch_dest : seq_addr;
      end
      if (rs.accept) begin
        in_slot <= dec_is_branch & ~in_slot;
      end
    end
  end
endmodule

// File: rtl/bres_chk.sv
module bres_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dec_valid,
  input logic              dec_ready,
  input logic              dec_is_branch,
  input logic              take_branch,
  input logic [ADDR_W-1:0] branch_dest,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              in_slot
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  p_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ready && !take_branch) |=> fetch_addr == $past(fetch_addr) + STEP);

  p_redirect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_branch |=> fetch_addr == $past(branch_dest));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_ready |=> $stable(fetch_addr));

  p_stall_no_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_ready |-> !take_branch);

  p_slot_no_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_slot |-> !take_branch);

  p_slot_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_ready && dec_is_branch && !in_slot) |=> in_slot);
endmodule

bind bres_top bres_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dec_valid    (dec_valid),
  .dec_ready    (dec_ready),
  .dec_is_branch(dec_is_branch),
  .take_branch  (take_branch),
  .branch_dest  (branch_dest),
  .fetch_addr   (fetch_addr),
  .in_slot      (in_slot)
);

// File: tb/tb_bres_top.sv
module tb_bres_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid = 1'b0;
  logic        dec_ready;
  logic [31:0] dec_pc = '0;
  logic        dec_is_branch = 1'b0;
  logic        dec_cmp_ne = 1'b0;
  logic [15:0] dec_offset = '0;
  logic [4:0]  dec_src_a = '0;
  logic [4:0]  dec_src_b = '0;
  logic [31:0] dec_opnd_a = '0;
  logic [31:0] dec_opnd_b = '0;
  logic        ld_in_ex = 1'b0;
  logic [4:0]  ld_dest = '0;
  logic [31:0] fetch_addr;
  logic        take_branch;
  logic [31:0] branch_dest;
  logic        in_slot;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_pc = '0;
  logic        m_slot = 1'b0;
  logic [31:0] m_dec_pc = '0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #10 clk = ~clk;

  bres_top dut (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req, input logic v, input logic br,
                      input logic ne, input logic [15:0] off,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic [4:0] ra, input logic [4:0] rb,
                      input logic ld, input logic [4:0] lrd);
    logic [31:0] e_dest;
    logic        e_stall, e_take;
    dec_valid = v; dec_is_branch = br; dec_cmp_ne = ne; dec_offset = off;
    dec_opnd_a = a; dec_opnd_b = b; dec_src_a = ra; dec_src_b = rb;
    ld_in_ex = ld; ld_dest = lrd; dec_pc = m_dec_pc;
    #1;
    e_dest  = m_dec_pc + 32'(signed'(off)) * 4;
    e_stall = v && br && ld && (lrd != 0) && (lrd == ra || lrd == rb);
    e_take  = v && br && !e_stall && !m_slot && (ne ? (a != b) : (a == b));
    chk(req, "fetch_addr", fetch_addr, m_pc);
    chk(req, "in_slot", 32'(in_slot), 32'(m_slot));
    chk(req, "dec_ready", 32'(dec_ready), 32'(!e_stall));
    chk(req, "take_branch", 32'(take_branch), 32'(e_take));
    chk(req, "branch_dest", branch_dest, e_dest);
    if (!e_stall) begin
      m_dec_pc = m_pc;
      m_pc = e_take ? e_dest : m_pc + 4;
      if (v) m_slot = br && !m_slot;
    end
    @(negedge clk);
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    #1;
    chk("R1", "fetch_addr in reset", fetch_addr, 32'h0);
    chk("R1", "in_slot in reset", 32'(in_slot), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: first cycle after reset
    step("R1", 0, 0, 0, 16'h0, 0, 0, 0, 0, 0, 0);
    // R2: plain instructions advance sequentially
    step("R2", 1, 0, 0, 16'h0, 1, 2, 1, 2, 0, 0);
    step("R2", 1, 0, 0, 16'h0, 1, 2, 1, 2, 0, 0);
    // R4/R5: equal-compare taken, then its slot (R6)
    step("R4", 1, 1, 0, 16'h0010, 32'h55, 32'h55, 3, 4, 0, 0);
    step("R6", 1, 0, 0, 16'h0, 0, 0, 0, 0, 0, 0);
    step("R5", 1, 0, 0, 16'h0, 0, 0, 0, 0, 0, 0);
    // R4: equal-compare not taken
    step("R4", 1, 1, 0, 16'h0008, 32'h1, 32'h2, 3, 4, 0, 0);
    step("R6", 1, 0, 0, 16'h0, 0, 0, 0, 0, 0, 0);
    // R4/R3: not-equal taken with negative offset
    step("R3", 1, 1, 1, 16'hFFF0, 32'h7, 32'h8, 3, 4, 0, 0);
    // R10: bubble while slot pending keeps slot state
    step("R10", 0, 0, 0, 16'h0, 0, 0, 0, 0, 0, 0);
    step("R10", 0, 1, 0, 16'h0, 0, 0, 0, 0, 0, 0);
    // R7: branch in slot is not taken
    step("R7", 1, 1, 0, 16'h0040, 32'h9, 32'h9, 3, 4, 0, 0);
    step("R7", 1, 0, 0, 16'h0, 0, 0, 0, 0, 0, 0);
    // R4: not-equal with equal operands, not taken
    step("R4", 1, 1, 1, 16'h0040, 32'h9, 32'h9, 3, 4, 0, 0);
    step("R6", 1, 0, 0, 16'h0, 0, 0, 0, 0, 0, 0);
    // R8: load-use stall on src a, then on src b, then release
    step("R8", 1, 1, 0, 16'h0020, 32'h3, 32'h3, 6, 7, 1, 6);
    step("R8", 1, 1, 0, 16'h0020, 32'h3, 32'h3, 6, 7, 1, 7);
    step("R8", 1, 1, 0, 16'h0020, 32'h3, 32'h3, 6, 7, 0, 7);
    step("R6", 1, 0, 0, 16'h0, 0, 0, 0, 0, 0, 0);
    // R9: load to register 0 and non-branch offers never stall
    step("R9", 1, 1, 1, 16'h0004, 32'h1, 32'h0, 0, 0, 1, 0);
    step("R9", 1, 0, 0, 16'h0, 0, 0, 5, 5, 1, 5);
    step("R9", 1, 0, 0, 16'h0, 0, 0, 5, 5, 1, 5);
    // R3: large offsets wrap
    step("R3", 1, 0, 0, 16'h7FFF, 0, 0, 0, 0, 0, 0);
    step("R3", 1, 0, 0, 16'h8000, 0, 0, 0, 0, 0, 0);
    // mixed pseudo-random stream
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r, opb;
      lfsr = nxt(lfsr); r = lfsr;
      lfsr = nxt(lfsr);
      opb = r[3] ? {28'h0, r[7:4]} : lfsr;
      step("R2", r[0] | r[1], r[2] & r[9], r[8], lfsr[15:0],
           {28'h0, r[7:4]}, opb, r[14:10], r[19:15],
           r[20] & r[21], r[24:22] == 0 ? 5'd0 : r[14:10] ^ {4'h0, r[25]});
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule